// File: doc/BRIEF.md
# Multi-PID TLB Matcher with Address Space

This block translates an effective address through a small, fully associative array of translation entries for an embedded memory-management unit. Each entry holds a valid flag, a translation ID, an effective page number, a real page number, a page-size code, an address-space bit and an eight-bit protection byte. A lookup compares every entry in parallel against the current process ID. When multi-ID operation is enabled, it also compares against a second and a third process ID. An entry must also carry the address-space bit that the access type selects. The lowest-numbered entry whose outcome is not a miss decides the result.

The result has four parts: a hit flag, a real address of up to 36 bits, the permission nibble that applied, and a two-bit result code. The code tells a grant, a miss, a data protection fault and an execute protection fault apart. Entries are loaded through a one-entry-per-cycle write port. A lookup request is answered one clock later.

Top module: `tlbm_lookup`

## Requirements
- R1: While `rst_n` is low and after it is released, `rsp_valid` is 0 and every entry is invalid, so any lookup before the first write returns code 2'b01 (miss).
- R2: A lookup presented with `lk_valid` high is answered in the next cycle with `rsp_valid` high. `rsp_valid` is low in a cycle that follows no request. A lookup presented in the same cycle as a write sees the array as it was before that write.
- R3: An entry matches an ID only when all three hold: it is valid; its translation ID is 0 (global) or equals that ID; and the effective address ANDed with the page mask equals the stored effective page number. The page size is 2^(10+size) bytes, and the mask clears that many low bits.
- R4: On a grant, the low 32 real-address bits are the real page number ANDed with the page mask, ORed with the effective-address offset bits below the mask.
- R5: With `single_pid` high, only `pid0` is compared, and `pid1`/`pid2` have no effect. A hit places the low 4 bits of the real page number into real-address bits [35:32].
- R6: With `single_pid` low, `pid1` is tried and then `pid2`, each only when it is nonzero. Real-address bits [35:32] are then 0.
- R7: After an ID match, the entry's address-space bit must equal `as_inst` for fetches or `as_data` for loads and stores. Otherwise the entry counts as a miss.
- R8: When `priv_user` is 1, the permission nibble is protection bits [3:0]; otherwise it is bits [7:4]. Within the nibble, bit 0 grants load, bit 1 grants store and bit 2 grants fetch. `acc_type` 2'b00 is a load, 2'b01 is a store, and 2'b10 or 2'b11 is a fetch.
- R9: Result codes: 2'b00 grant, 2'b01 miss, 2'b10 data violation (a load or store without its permission bit), 2'b11 execute violation (a fetch without its permission bit). `rsp_hit` is 1 exactly on a grant.
- R10: The lowest-indexed entry whose outcome is not a miss decides the result. A protection fault in a lower entry hides a grant in a higher one, but an address-space mismatch does not.
- R11: On a miss, `rsp_ra` and `rsp_perm` are 0. On a fault, `rsp_ra` is 0 and `rsp_perm` holds the nibble that was checked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write one entry this cycle |
| wr_idx | input | IDX_W | Entry index to write |
| wr_valid | input | 1 | Valid flag for the written entry |
| wr_tid | input | PID_W | Translation ID (0 = global) |
| wr_epn | input | EA_W | Effective page number (aligned address) |
| wr_rpn | input | EA_W | Real page number |
| wr_size | input | SZ_W | Page size code |
| wr_as | input | 1 | Address-space bit of the entry |
| wr_prot | input | 8 | Protection: [7:4] supervisor, [3:0] user |
| lk_valid | input | 1 | Lookup request |
| lk_ea | input | EA_W | Effective address |
| pid0 | input | PID_W | Primary process ID |
| pid1 | input | PID_W | Secondary process ID |
| pid2 | input | PID_W | Tertiary process ID |
| as_inst | input | 1 | Address space for fetches |
| as_data | input | 1 | Address space for loads and stores |
| priv_user | input | 1 | 1 = user mode |
| acc_type | input | 2 | Access type (see R8) |
| single_pid | input | 1 | 1 = single-ID mode with address widening |
| rsp_valid | output | 1 | Response valid |
| rsp_hit | output | 1 | Access granted |
| rsp_ra | output | RA_W | Real address (36 bits by default) |
| rsp_perm | output | 4 | Applied permission nibble |
| rsp_code | output | 2 | Result code (see R9) |

## Verification
Directed lookups place one entry so that each rule decides the outcome on its own. These cases cover the ID being correct or wrong, a zero ID and a global entry, each mode flag, each address-space bit, each privilege level and each access type. They separate a miss from the two fault kinds, and 36-bit widening from 32-bit output. Stacked entries that share one page tell a fault ahead of a grant apart from an address-space mismatch ahead of a grant. The page-edge and same-cycle-write cases probe the mask width and the write timing. Random traffic then mixes sizes, overlapping pages, small ID values and random protection bytes so that several entries compete, and every response is compared with a bench model written in shift arithmetic.

// File: rtl/tlbm_pkg.sv
package tlbm_pkg;

  typedef enum logic [1:0] {
    RC_GRANT = 2'b00,
    RC_MISS  = 2'b01,
    RC_DVIOL = 2'b10,
    RC_XVIOL = 2'b11
  } rc_e;

  localparam logic [1:0] ACC_LOAD  = 2'b00;
  localparam logic [1:0] ACC_STORE = 2'b01;
  localparam logic [1:0] ACC_FETCH = 2'b10;

  // one-hot nibble bit required by an access type (fetch when bit 1 set)
  function automatic logic [3:0] need_bit(input logic [1:0] acc);
    if (acc[1])      need_bit = 4'b0100;
    else if (acc[0]) need_bit = 4'b0010;
    else             need_bit = 4'b0001;
  endfunction

  function automatic logic perm_ok(input logic [3:0] nib, input logic [1:0] acc);
    perm_ok = |(nib & need_bit(acc));
  endfunction

  function automatic logic [3:0] pick_nib(input logic [7:0] prot, input logic user);
    pick_nib = user ? prot[3:0] : prot[7:4];
  endfunction

endpackage

// File: rtl/tlbm_store.sv
module tlbm_store #(
  parameter int ENTRIES = 8,
  parameter int EA_W    = 32,
  parameter int PID_W   = 8,
  parameter int SZ_W    = 4,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [IDX_W-1:0]                 wr_idx,
  input  logic                             wr_valid,
  input  logic [PID_W-1:0]                 wr_tid,
  input  logic [EA_W-1:0]                  wr_epn,
  input  logic [EA_W-1:0]                  wr_rpn,
  input  logic [SZ_W-1:0]                  wr_size,
  input  logic                             wr_as,
  input  logic [7:0]                       wr_prot,
  output logic [ENTRIES-1:0]               st_valid,
  output logic [ENTRIES-1:0][PID_W-1:0]    st_tid,
  output logic [ENTRIES-1:0][EA_W-1:0]     st_epn,
  output logic [ENTRIES-1:0][EA_W-1:0]     st_rpn,
  output logic [ENTRIES-1:0][SZ_W-1:0]     st_size,
  output logic [ENTRIES-1:0]               st_as,
  output logic [ENTRIES-1:0][7:0]          st_prot
);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic sel;
    assign sel = wr_en && (int'(wr_idx) == g);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_valid[g] <= 1'b0;
        st_tid[g]   <= '0;
        st_epn[g]   <= '0;
        st_rpn[g]   <= '0;
        st_size[g]  <= '0;
        st_as[g]    <= 1'b0;
        st_prot[g]  <= '0;
      end else if (sel) begin
        st_valid[g] <= wr_valid;
        st_tid[g]   <= wr_tid;
        st_epn[g]   <= wr_epn;
        st_rpn[g]   <= wr_rpn;
        st_size[g]  <= wr_size;
        st_as[g]    <= wr_as;
        st_prot[g]  <= wr_prot;
      end
    end
  end

endmodule

// File: rtl/tlbm_match.sv
module tlbm_match
  import tlbm_pkg::*;
#(
  parameter int EA_W      = 32,
  parameter int PID_W     = 8,
  parameter int SZ_W      = 4,
  parameter int MIN_SHIFT = 10,
  localparam int RA_W     = EA_W + 4
) (
  input  logic              e_valid,
  input  logic [PID_W-1:0]  e_tid,
  input  logic [EA_W-1:0]   e_epn,
  input  logic [EA_W-1:0]   e_rpn,
  input  logic [SZ_W-1:0]   e_size,
  input  logic              e_as,
  input  logic [7:0]        e_prot,
  input  logic [EA_W-1:0]   ea,
  input  logic [PID_W-1:0]  pid0,
  input  logic [PID_W-1:0]  pid1,
  input  logic [PID_W-1:0]  pid2,
  input  logic              as_inst,
  input  logic              as_data,
  input  logic              user,
  input  logic [1:0]        acc,
  input  logic              single,
  output logic [1:0]        code,
  output logic [RA_W-1:0]   ra,
  output logic [3:0]        nib,
  output logic              id_hit
);

  function automatic logic [EA_W-1:0] page_mask(input logic [SZ_W-1:0] sz);
    logic [EA_W-1:0] m;
    m = '1;
    page_mask = m << (MIN_SHIFT + int'(sz));
  endfunction

  function automatic logic id_match(input logic [PID_W-1:0] tid,
                                    input logic [PID_W-1:0] pid);
    id_match = (tid == '0) || (tid == pid);
  endfunction

  logic [EA_W-1:0] mask;
  logic            page_eq;
  logic            hit0, hit1, hit2;
  logic            as_ok;
  logic            fetch;

  assign mask    = page_mask(e_size);
  assign page_eq = e_valid && ((ea & mask) == e_epn);
  assign hit0    = page_eq && id_match(e_tid, pid0);
  assign hit1    = page_eq && !single && (pid1 != '0) && id_match(e_tid, pid1);
  assign hit2    = page_eq && !single && (pid2 != '0) && id_match(e_tid, pid2);
  assign id_hit  = hit0 || hit1 || hit2;

  assign fetch   = acc[1];
  assign as_ok   = (e_as == (fetch ? as_inst : as_data));
  assign nib     = pick_nib(e_prot, user);

  always_comb begin
    ra = '0;
    ra[EA_W-1:0] = (e_rpn & mask) | (ea & ~mask);
    if (single && hit0) ra[RA_W-1:EA_W] = e_rpn[3:0];
  end

  always_comb begin
    if (!id_hit || !as_ok)      code = RC_MISS;
    else if (perm_ok(nib, acc)) code = RC_GRANT;
    else if (fetch)             code = RC_XVIOL;
    else                        code = RC_DVIOL;
  end

endmodule

// File: rtl/tlbm_pick.sv
module tlbm_pick
  import tlbm_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int RA_W    = 36
) (
  input  logic [ENTRIES-1:0][1:0]       e_code,
  input  logic [ENTRIES-1:0][RA_W-1:0]  e_ra,
  input  logic [ENTRIES-1:0][3:0]       e_nib,
  output logic [ENTRIES-1:0]            sel_vec,
  output logic [1:0]                    code,
  output logic [RA_W-1:0]               ra,
  output logic [3:0]                    nib
);

  always_comb begin
    logic found;
    found   = 1'b0;
    sel_vec = '0;
    code    = RC_MISS;
    ra      = '0;
    nib     = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!found && e_code[i] != RC_MISS) begin
        found      = 1'b1;
        sel_vec[i] = 1'b1;
        code       = e_code[i];
        nib        = e_nib[i];
        ra         = (e_code[i] == RC_GRANT) ? e_ra[i] : '0;
      end
    end
  end

endmodule

// File: rtl/tlbm_lookup.sv
module tlbm_lookup
  import tlbm_pkg::*;
#(
  parameter int ENTRIES   = 8,
  parameter int EA_W      = 32,
  parameter int PID_W     = 8,
  parameter int SZ_W      = 4,
  parameter int MIN_SHIFT = 10,
  localparam int IDX_W    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int RA_W     = EA_W + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_valid,
  input  logic [PID_W-1:0]  wr_tid,
  input  logic [EA_W-1:0]   wr_epn,
  input  logic [EA_W-1:0]   wr_rpn,
  input  logic [SZ_W-1:0]   wr_size,
  input  logic              wr_as,
  input  logic [7:0]        wr_prot,
  input  logic              lk_valid,
  input  logic [EA_W-1:0]   lk_ea,
  input  logic [PID_W-1:0]  pid0,
  input  logic [PID_W-1:0]  pid1,
  input  logic [PID_W-1:0]  pid2,
  input  logic              as_inst,
  input  logic              as_data,
  input  logic              priv_user,
  input  logic [1:0]        acc_type,
  input  logic              single_pid,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [RA_W-1:0]   rsp_ra,
  output logic [3:0]        rsp_perm,
  output logic [1:0]        rsp_code
);

  logic [ENTRIES-1:0]             st_valid;
  logic [ENTRIES-1:0][PID_W-1:0]  st_tid;
  logic [ENTRIES-1:0][EA_W-1:0]   st_epn;
  logic [ENTRIES-1:0][EA_W-1:0]   st_rpn;
  logic [ENTRIES-1:0][SZ_W-1:0]   st_size;
  logic [ENTRIES-1:0]             st_as;
  logic [ENTRIES-1:0][7:0]        st_prot;

  logic [ENTRIES-1:0][1:0]        ent_code;
  logic [ENTRIES-1:0][RA_W-1:0]   ent_ra;
  logic [ENTRIES-1:0][3:0]        ent_nib;
  logic [ENTRIES-1:0]             ent_id_hit;

  logic [ENTRIES-1:0]             first_hit_vec;
  logic [1:0]                     nxt_code;
  logic [RA_W-1:0]                nxt_ra;
  logic [3:0]                     nxt_nib;

  tlbm_store #(
    .ENTRIES(ENTRIES), .EA_W(EA_W), .PID_W(PID_W), .SZ_W(SZ_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid), .wr_tid(wr_tid),
    .wr_epn(wr_epn), .wr_rpn(wr_rpn), .wr_size(wr_size), .wr_as(wr_as),
    .wr_prot(wr_prot),
    .st_valid(st_valid), .st_tid(st_tid), .st_epn(st_epn), .st_rpn(st_rpn),
    .st_size(st_size), .st_as(st_as), .st_prot(st_prot)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_match
    tlbm_match #(
      .EA_W(EA_W), .PID_W(PID_W), .SZ_W(SZ_W), .MIN_SHIFT(MIN_SHIFT)
    ) u_match (
      .e_valid(st_valid[g]), .e_tid(st_tid[g]), .e_epn(st_epn[g]),
      .e_rpn(st_rpn[g]), .e_size(st_size[g]), .e_as(st_as[g]),
      .e_prot(st_prot[g]),
      .ea(lk_ea), .pid0(pid0), .pid1(pid1), .pid2(pid2),
      .as_inst(as_inst), .as_data(as_data), .user(priv_user),
      .acc(acc_type), .single(single_pid),
      .code(ent_code[g]), .ra(ent_ra[g]), .nib(ent_nib[g]),
      .id_hit(ent_id_hit[g])
    );
  end

  tlbm_pick #(.ENTRIES(ENTRIES), .RA_W(RA_W)) u_pick (
    .e_code(ent_code), .e_ra(ent_ra), .e_nib(ent_nib),
    .sel_vec(first_hit_vec), .code(nxt_code), .ra(nxt_ra), .nib(nxt_nib)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_ra    <= '0;
      rsp_perm  <= '0;
      rsp_code  <= RC_MISS;
    end else begin
      rsp_valid <= lk_valid;
      if (lk_valid) begin
        rsp_hit  <= (nxt_code == RC_GRANT);
        rsp_ra   <= nxt_ra;
        rsp_perm <= nxt_nib;
        rsp_code <= nxt_code;
      end
    end
  end

endmodule

// File: rtl/tlbm_lookup_chk.sv
module tlbm_lookup_chk
  import tlbm_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int EA_W    = 32,
  localparam int RA_W   = EA_W + 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_valid,
  input logic [1:0]         acc_type,
  input logic               single_pid,
  input logic               rsp_valid,
  input logic               rsp_hit,
  input logic [RA_W-1:0]    rsp_ra,
  input logic [3:0]         rsp_perm,
  input logic [1:0]         rsp_code,
  input logic [ENTRIES-1:0] first_hit_vec,
  input logic [ENTRIES-1:0] ent_id_hit
);

  assert_answer_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);

  assert_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid);

  assert_miss_clean_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code == RC_MISS) |-> (rsp_ra == '0 && rsp_perm == 4'h0 && !rsp_hit));

  assert_xviol_fetch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code == RC_XVIOL) |-> $past(acc_type[1]));

  assert_dviol_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code == RC_DVIOL) |-> !$past(acc_type[1]));

  assert_narrow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !$past(single_pid)) |-> (rsp_ra[RA_W-1:EA_W] == 4'h0));

  assert_store_perm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code == RC_DVIOL && $past(acc_type) == ACC_STORE) |-> !rsp_perm[1]);

  assert_first_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(first_hit_vec));

  assert_sel_needs_id_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (first_hit_vec & ~ent_id_hit) == '0);

endmodule

bind tlbm_lookup tlbm_lookup_chk #(.ENTRIES(ENTRIES), .EA_W(EA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .acc_type(acc_type),
  .single_pid(single_pid), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
  .rsp_ra(rsp_ra), .rsp_perm(rsp_perm), .rsp_code(rsp_code),
  .first_hit_vec(first_hit_vec), .ent_id_hit(ent_id_hit)
);

// File: tb/tb_tlbm_lookup.sv
module tb_tlbm_lookup;

  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int WATCHDOG = 100000;

  logic        clk, rst_n;
  logic        wr_en, wr_valid, wr_as;
  logic [2:0]  wr_idx;
  logic [7:0]  wr_tid, wr_prot;
  logic [31:0] wr_epn, wr_rpn;
  logic [3:0]  wr_size;
  logic        lk_valid, as_inst, as_data, priv_user, single_pid;
  logic [31:0] lk_ea;
  logic [7:0]  pid0, pid1, pid2;
  logic [1:0]  acc_type;
  logic        rsp_valid, rsp_hit;
  logic [35:0] rsp_ra;
  logic [3:0]  rsp_perm;
  logic [1:0]  rsp_code;

  int total = 0;
  int bad   = 0;

  // bench copy of the array contents
  logic        m_valid [N];
  logic [7:0]  m_tid   [N];
  logic [31:0] m_epn   [N];
  logic [31:0] m_rpn   [N];
  logic [3:0]  m_sz    [N];
  logic        m_as    [N];
  logic [7:0]  m_prot  [N];

  tlbm_lookup dut (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid), .wr_tid(wr_tid),
    .wr_epn(wr_epn), .wr_rpn(wr_rpn), .wr_size(wr_size), .wr_as(wr_as),
    .wr_prot(wr_prot),
    .lk_valid(lk_valid), .lk_ea(lk_ea), .pid0(pid0), .pid1(pid1), .pid2(pid2),
    .as_inst(as_inst), .as_data(as_data), .priv_user(priv_user),
    .acc_type(acc_type), .single_pid(single_pid),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_ra(rsp_ra),
    .rsp_perm(rsp_perm), .rsp_code(rsp_code)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic check(input bit ok, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // independent model: page compare by shifting, offset by subtraction
  task automatic model(input logic [31:0] ea, input logic [7:0] p0, p1, p2,
                       input logic ai, ad, usr, input logic [1:0] acc,
                       input logic sgl, output logic [1:0] c,
                       output logic [35:0] ra, output logic [3:0] nib);
    c = 2'b01; ra = '0; nib = '0;
    for (int i = 0; i < N; i++) begin
      int pb;
      logic pg, h0, h1, h2, fe;
      logic [3:0] n;
      int bp;
      pb = 10 + int'(m_sz[i]);
      pg = m_valid[i] && (((ea >> pb) << pb) == m_epn[i]);
      h0 = (m_tid[i] == 8'd0) || (m_tid[i] == p0);
      h1 = !sgl && (p1 != 8'd0) && ((m_tid[i] == 8'd0) || (m_tid[i] == p1));
      h2 = !sgl && (p2 != 8'd0) && ((m_tid[i] == 8'd0) || (m_tid[i] == p2));
      fe = acc[1];
      if (pg && (h0 || h1 || h2) && (m_as[i] == (fe ? ai : ad))) begin
        n = usr ? m_prot[i][3:0] : m_prot[i][7:4];
        bp = fe ? 2 : (acc[0] ? 1 : 0);
        nib = n;
        if (n[bp]) begin
          c = 2'b00;
          ra[31:0] = ((m_rpn[i] >> pb) << pb) | (ea - ((ea >> pb) << pb));
          if (sgl && h0) ra[35:32] = m_rpn[i][3:0];
        end else begin
          c = fe ? 2'b11 : 2'b10;
        end
        break;
      end
    end
  endtask

  task automatic wr(input int idx, input logic v, input logic [7:0] tid,
                    input logic [31:0] epn, input logic [31:0] rpn,
                    input logic [3:0] sz, input logic as, input logic [7:0] prot);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx[2:0]; wr_valid = v; wr_tid = tid;
    wr_epn = epn; wr_rpn = rpn; wr_size = sz; wr_as = as; wr_prot = prot;
    @(posedge clk);
    #1 wr_en = 1'b0;
    m_valid[idx] = v; m_tid[idx] = tid; m_epn[idx] = epn; m_rpn[idx] = rpn;
    m_sz[idx] = sz; m_as[idx] = as; m_prot[idx] = prot;
  endtask

  task automatic look(input logic [31:0] ea, input logic [7:0] p0, p1, p2,
                      input logic ai, ad, usr, input logic [1:0] acc,
                      input logic sgl, input string tag);
    logic [1:0] ec; logic [35:0] era; logic [3:0] en;
    @(negedge clk);
    lk_valid = 1'b1; lk_ea = ea; pid0 = p0; pid1 = p1; pid2 = p2;
    as_inst = ai; as_data = ad; priv_user = usr; acc_type = acc; single_pid = sgl;
    model(ea, p0, p1, p2, ai, ad, usr, acc, sgl, ec, era, en);
    @(posedge clk);
    @(negedge clk);
    lk_valid = 1'b0;
    check(rsp_valid && rsp_code == ec && rsp_hit == (ec == 2'b00) &&
          rsp_ra == era && rsp_perm == en, tag,
          {rsp_valid, rsp_hit, rsp_code, rsp_perm, rsp_ra},
          {1'b1, ec == 2'b00, ec, en, era});
  endtask

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < N; i++) begin
      m_valid[i] = 0; m_tid[i] = 0; m_epn[i] = 0; m_rpn[i] = 0;
      m_sz[i] = 0; m_as[i] = 0; m_prot[i] = 0;
    end
    rst_n = 1'b0; wr_en = 0; wr_idx = 0; wr_valid = 0; wr_tid = 0; wr_epn = 0;
    wr_rpn = 0; wr_size = 0; wr_as = 0; wr_prot = 0; lk_valid = 0; lk_ea = 0;
    pid0 = 0; pid1 = 0; pid2 = 0; as_inst = 0; as_data = 0; priv_user = 0;
    acc_type = 0; single_pid = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!rsp_valid && rsp_code == 2'b01, "R1 reset state", {rsp_valid, rsp_code}, 3'b001);
    rst_n = 1'b1;
    look(32'h0000_0000, 8'd0, 0, 0, 0, 0, 0, 2'b00, 0, "R1 empty array misses");
    @(negedge clk);
    check(!rsp_valid, "R2 no request no response", rsp_valid, 0);

    // entry 0: tid 5, 4 KiB page at 0x10000, supervisor read only
    wr(0, 1, 8'd5, 32'h0001_0000, 32'h8000_3007, 4'd2, 0, 8'h11);
    look(32'h0001_0123, 8'd5, 0, 0, 0, 0, 0, 2'b00, 1, "R5 widened hit");
    check(rsp_ra == 36'h7_8000_3123, "R5 literal widened address", rsp_ra, 36'h7_8000_3123);
    look(32'h0001_0123, 8'd5, 0, 0, 0, 0, 0, 2'b00, 0, "R4 offset merge narrow");
    check(rsp_ra == 36'h0_8000_3123, "R4 literal address", rsp_ra, 36'h0_8000_3123);
    look(32'h0001_0123, 8'd6, 0, 0, 0, 0, 0, 2'b00, 0, "R3 wrong pid misses");
    look(32'h0001_1000, 8'd5, 0, 0, 0, 0, 0, 2'b00, 0, "R3 just past page misses");
    look(32'h0001_0FFF, 8'd5, 0, 0, 0, 0, 0, 2'b00, 0, "R3 last byte of page");
    look(32'h0001_0123, 8'd9, 8'd5, 0, 0, 0, 0, 2'b00, 1, "R5 pid1 ignored in single mode");
    look(32'h0001_0123, 8'd9, 8'd5, 0, 0, 0, 0, 2'b00, 0, "R6 pid1 match");
    look(32'h0001_0123, 8'd9, 8'd7, 8'd5, 0, 0, 0, 2'b00, 0, "R6 pid2 match");
    look(32'h0001_0123, 8'd9, 8'd0, 8'd0, 0, 0, 0, 2'b00, 0, "R6 zero pids skipped");
    look(32'h0001_0123, 8'd5, 0, 0, 0, 0, 1, 2'b00, 0, "R8 user nibble read");
    look(32'h0001_0123, 8'd5, 0, 0, 0, 0, 0, 2'b01, 0, "R9 store data violation");
    look(32'h0001_0123, 8'd5, 0, 0, 0, 0, 0, 2'b10, 0, "R9 fetch execute violation");
    look(32'h0001_0123, 8'd5, 0, 0, 0, 1, 0, 2'b00, 0, "R7 data space mismatch");

    // entry 1: global, 1 KiB, address space 1, supervisor RWX user X
    wr(1, 1, 8'd0, 32'h0002_0400, 32'h0055_0000, 4'd0, 1, 8'h74);
    look(32'h0002_0410, 8'd3, 0, 0, 1, 0, 0, 2'b10, 0, "R7 fetch uses inst space");
    look(32'h0002_0410, 8'd3, 0, 0, 0, 1, 0, 2'b10, 0, "R7 fetch ignores data space");
    look(32'h0002_0410, 8'd200, 0, 0, 0, 1, 0, 2'b01, 1, "R3 global entry any pid");
    look(32'h0002_0410, 8'd3, 0, 0, 1, 0, 1, 2'b11, 0, "R8 user fetch code 11");
    look(32'h0002_0410, 8'd3, 0, 0, 0, 1, 1, 2'b00, 0, "R11 user load fault nibble");

    // priority: entry 2 faults, entry 3 grants on the same page
    wr(2, 1, 8'd4, 32'h0003_0000, 32'h0011_0000, 4'd2, 0, 8'h10);
    wr(3, 1, 8'd4, 32'h0003_0000, 32'h0022_0000, 4'd2, 0, 8'h70);
    look(32'h0003_0044, 8'd4, 0, 0, 0, 0, 0, 2'b01, 0, "R10 earlier fault hides grant");
    check(rsp_code == 2'b10, "R10 literal fault code", rsp_code, 2'b10);
    wr(2, 1, 8'd4, 32'h0003_0000, 32'h0011_0000, 4'd2, 1, 8'h10);
    look(32'h0003_0044, 8'd4, 0, 0, 0, 0, 0, 2'b01, 0, "R10 space mismatch does not hide");
    check(rsp_ra == 36'h0_0022_0044, "R10 later entry used", rsp_ra, 36'h0_0022_0044);

    // same-cycle write and lookup sees old contents
    @(negedge clk);
    wr_en = 1; wr_idx = 3'd4; wr_valid = 1; wr_tid = 8'd0; wr_epn = 32'h0004_0000;
    wr_rpn = 32'h0099_0000; wr_size = 4'd2; wr_as = 0; wr_prot = 8'hFF;
    lk_valid = 1; lk_ea = 32'h0004_0010; pid0 = 8'd1; pid1 = 0; pid2 = 0;
    as_inst = 0; as_data = 0; priv_user = 0; acc_type = 2'b00; single_pid = 0;
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; lk_valid = 0;
    check(rsp_code == 2'b01, "R2 lookup sees pre-write array", rsp_code, 2'b01);
    m_valid[4] = 1; m_tid[4] = 0; m_epn[4] = 32'h0004_0000; m_rpn[4] = 32'h0099_0000;
    m_sz[4] = 2; m_as[4] = 0; m_prot[4] = 8'hFF;
    look(32'h0004_0010, 8'd1, 0, 0, 0, 0, 0, 2'b00, 0, "R2 write visible next lookup");

    // constrained random traffic
    for (int k = 0; k < 400; k++) begin
      if (($urandom % 4) == 0) begin
        logic [3:0] s;
        logic [31:0] e;
        s = 4'($urandom % 4);
        e = ((32'($urandom % 16)) << 10) & (32'hFFFF_FFFF << (10 + int'(s)));
        wr($urandom % N, ($urandom % 8) != 0, 8'($urandom % 4), e, $urandom,
           s, 1'($urandom), 8'($urandom));
      end
      look(32'($urandom % 32'h4000), 8'($urandom % 4), 8'($urandom % 4),
           8'($urandom % 4), 1'($urandom), 1'($urandom), 1'($urandom),
           2'($urandom), 1'($urandom), "R3 R8 R9 R10 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule